// File: doc/BRIEF.md
# Mean-Subtracted PCA Projection Engine

This block turns one signal vector into a short feature vector by projecting it onto a stored set of principal-component basis rows. A stored mean vector is first taken away from the test samples, element by element. The centred vector is then multiplied element-wise against each basis row, and the products are summed into one coefficient per row. The result is an M-element feature vector that a later stage can compare against enrolled feature vectors.

The test vector, the mean vector and the basis matrix are loaded through one addressed write port. A one-cycle start request launches a projection. The block streams one element per clock through a three-stage multiply-accumulate pipeline and raises a one-cycle completion pulse. Coefficients are then read through an indexed read port at any time. All arithmetic is signed two's-complement integer. The accumulator is sized so that no sum of N products can overflow.

Top module: `pcaproj_engine`

## Requirements
- R1: A write with `vec_we` high stores `vec_wdata` at the edge. `vec_sel` 0 selects the test vector and 1 selects the mean vector, each with element index `vec_addr` (0..N_LEN-1). `vec_sel` 2 selects the basis matrix at flat index `vec_addr` = row*N_LEN + column. `vec_sel` 3 stores nothing.
- R2: After reset, `busy` and `done` are low and every coefficient reads as zero.
- R3: A `start` sampled high while `busy` is low raises `busy` after that edge. `done` is then high in the cycle that follows the (M_ROWS*N_LEN+2)-th rising edge after the start edge.
- R4: `done` is high for exactly one cycle. `busy` falls at the same edge where `done` rises.
- R5: Coefficient r equals the sum over columns c of (test[c] - mean[c]) * basis[r][c]. All operands are signed 32-bit values, and the mean is subtracted before any multiplication.
- R6: Coefficients are `ACC_W` = 2*DATA_W+1+ceil(log2(N_LEN)) bits wide, so they are exact even when every operand is at its most negative or most positive value.
- R7: A `start` while `busy` is high is ignored. It neither restarts nor lengthens the run.
- R8: Writes presented while `busy` is high are discarded. The stored vectors keep their earlier contents for this run and for later runs.
- R9: Each coefficient depends only on its own row's products. Nothing carries over from a previous row or a previous run.
- R10: `rd_coef` shows coefficient `rd_idx` with no clock delay. It stays constant while the block is idle and `rd_idx` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_we | input | 1 | Write strobe for vector and basis storage |
| vec_sel | input | 2 | Target select: 0 test, 1 mean, 2 basis, 3 none |
| vec_addr | input | AW | Element index (flat row*N_LEN+column for basis) |
| vec_wdata | input | DATA_W | Signed value to store |
| start | input | 1 | Request a projection |
| busy | output | 1 | Projection in progress |
| done | output | 1 | One-cycle pulse when the last coefficient is written |
| rd_idx | input | RW | Coefficient index to read |
| rd_coef | output | ACC_W | Signed coefficient selected by `rd_idx` |

## Verification
`busy` is due one edge after an accepted start. `done` is due exactly M_ROWS*N_LEN+2 edges after that start and lasts one cycle. Coefficients change only at the edge where their row finishes, and all rows are final once `done` is seen. The bench model holds a countdown loaded at each accepted start. It compares `busy` and `done` against that countdown on every falling edge, half a cycle after the registers settle. Coefficients are read only while idle, 1 ns after `rd_idx` is driven, and are compared with sums the model took from the vectors it captured at the accepted start.

// File: rtl/pcaproj_pkg.sv
package pcaproj_pkg;

  // Sequencer phases
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_RUN   = 2'd1,
    SEQ_DRAIN = 2'd2
  } seq_state_e;

  // Write-port target select codes
  localparam logic [1:0] SEL_TEST  = 2'd0;
  localparam logic [1:0] SEL_MEAN  = 2'd1;
  localparam logic [1:0] SEL_BASIS = 2'd2;

endpackage

// File: rtl/pcaproj_store.sv
module pcaproj_store
  import pcaproj_pkg::*;
#(
  parameter int N_LEN  = 300,
  parameter int M_ROWS = 4,
  parameter int DATA_W = 32,
  localparam int CW    = (N_LEN > 1) ? $clog2(N_LEN) : 1,
  localparam int DEPTH = M_ROWS * N_LEN,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CW-1:0]     rd_col,
  input  logic [AW-1:0]     rd_bidx,
  output logic [DATA_W-1:0] test_q,
  output logic [DATA_W-1:0] mean_q,
  output logic [DATA_W-1:0] basis_q
);

  logic [DATA_W-1:0] test_mem  [N_LEN];
  logic [DATA_W-1:0] mean_mem  [N_LEN];
  logic [DATA_W-1:0] basis_mem [DEPTH];

  logic in_vec_range;
  logic in_mat_range;
  logic test_en, mean_en, basis_en;

  assign in_vec_range = (wr_addr < AW'(N_LEN));
  assign in_mat_range = (32'(wr_addr) < DEPTH);

  assign test_en  = wr_en && (wr_sel == SEL_TEST)  && in_vec_range;
  assign mean_en  = wr_en && (wr_sel == SEL_MEAN)  && in_vec_range;
  assign basis_en = wr_en && (wr_sel == SEL_BASIS) && in_mat_range;

  always_ff @(posedge clk) begin
    if (test_en) test_mem[wr_addr[CW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (mean_en) mean_mem[wr_addr[CW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (basis_en) basis_mem[wr_addr] <= wr_data;
  end

  assign test_q  = test_mem[rd_col];
  assign mean_q  = mean_mem[rd_col];
  assign basis_q = basis_mem[rd_bidx];

endmodule

// File: rtl/pcaproj_seq.sv
module pcaproj_seq
  import pcaproj_pkg::*;
#(
  parameter int N_LEN  = 300,
  parameter int M_ROWS = 4,
  localparam int CW    = (N_LEN > 1) ? $clog2(N_LEN) : 1,
  localparam int RW    = (M_ROWS > 1) ? $clog2(M_ROWS) : 1,
  localparam int DEPTH = M_ROWS * N_LEN,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          fin,
  output logic          busy,
  output logic          done,
  output logic          iss_vld,
  output logic          iss_first,
  output logic          iss_last,
  output logic [RW-1:0] iss_row,
  output logic [CW-1:0] iss_col,
  output logic [AW-1:0] iss_bidx
);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] col_q, col_d;
  logic [RW-1:0] row_q, row_d;
  logic [AW-1:0] bidx_q, bidx_d;
  logic          ctr_en;
  logic          col_last, row_last;
  logic          done_q;

  assign col_last = (col_q == CW'(N_LEN - 1));
  assign row_last = (row_q == RW'(M_ROWS - 1));

  always_comb begin
    state_d = state_q;
    col_d   = col_q;
    row_d   = row_q;
    bidx_d  = bidx_q;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start) begin
          state_d = SEQ_RUN;
          col_d   = '0;
          row_d   = '0;
          bidx_d  = '0;
        end
      end
      SEQ_RUN: begin
        bidx_d = bidx_q + AW'(1);
        if (col_last) begin
          col_d = '0;
          if (row_last) state_d = SEQ_DRAIN;
          else          row_d   = row_q + RW'(1);
        end else begin
          col_d = col_q + CW'(1);
        end
      end
      SEQ_DRAIN: begin
        if (fin) state_d = SEQ_IDLE;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  assign ctr_en = (state_q == SEQ_RUN) || ((state_q == SEQ_IDLE) && start);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      row_q  <= '0;
      bidx_q <= '0;
    end else if (ctr_en) begin
      col_q  <= col_d;
      row_q  <= row_d;
      bidx_q <= bidx_d;
    end
  end

  assign busy      = (state_q != SEQ_IDLE);
  assign done      = done_q;
  assign iss_vld   = (state_q == SEQ_RUN);
  assign iss_first = (col_q == '0);
  assign iss_last  = col_last;
  assign iss_row   = row_q;
  assign iss_col   = col_q;
  assign iss_bidx  = bidx_q;

endmodule

// File: rtl/pcaproj_mac.sv
module pcaproj_mac #(
  parameter int N_LEN  = 300,
  parameter int M_ROWS = 4,
  parameter int DATA_W = 32,
  localparam int RW    = (M_ROWS > 1) ? $clog2(M_ROWS) : 1,
  localparam int DW    = DATA_W + 1,
  localparam int PW    = DW + DATA_W,
  localparam int ACC_W = PW + ((N_LEN > 1) ? $clog2(N_LEN) : 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic              in_first,
  input  logic              in_last,
  input  logic [RW-1:0]     in_row,
  input  logic [DATA_W-1:0] test_i,
  input  logic [DATA_W-1:0] mean_i,
  input  logic [DATA_W-1:0] basis_i,
  output logic              wr_vld,
  output logic [RW-1:0]     wr_row,
  output logic [ACC_W-1:0]  wr_val,
  output logic              fin
);

  // Stage A: centred sample and basis element
  logic                     a_vld, a_first, a_last;
  logic [RW-1:0]            a_row;
  logic signed [DW-1:0]     a_diff;
  logic signed [DATA_W-1:0] a_coef;

  // Stage B: full-precision product
  logic                     b_vld, b_first, b_last;
  logic [RW-1:0]            b_row;
  logic signed [PW-1:0]     b_prod;

  // Stage C: running sum
  logic signed [ACC_W-1:0]  acc_q, acc_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_vld <= 1'b0;
      b_vld <= 1'b0;
    end else begin
      a_vld <= in_vld;
      b_vld <= a_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (in_vld) begin
      a_first <= in_first;
      a_last  <= in_last;
      a_row   <= in_row;
      a_diff  <= $signed({test_i[DATA_W-1], test_i}) - $signed({mean_i[DATA_W-1], mean_i});
      a_coef  <= basis_i;
    end
  end

  always_ff @(posedge clk) begin
    if (a_vld) begin
      b_first <= a_first;
      b_last  <= a_last;
      b_row   <= a_row;
      b_prod  <= PW'(a_diff) * PW'(a_coef);
    end
  end

  always_comb begin
    if (b_first) acc_d = ACC_W'(b_prod);
    else         acc_d = acc_q + ACC_W'(b_prod);
  end

  always_ff @(posedge clk) begin
    if (b_vld) acc_q <= acc_d;
  end

  assign wr_vld = b_vld && b_last;
  assign wr_row = b_row;
  assign wr_val = acc_d;
  assign fin    = wr_vld && (b_row == RW'(M_ROWS - 1));

endmodule

// File: rtl/pcaproj_result.sv
module pcaproj_result #(
  parameter int M_ROWS = 4,
  parameter int ACC_W  = 74,
  localparam int RW    = (M_ROWS > 1) ? $clog2(M_ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_vld,
  input  logic [RW-1:0]    wr_row,
  input  logic [ACC_W-1:0] wr_val,
  input  logic [RW-1:0]    rd_idx,
  output logic [ACC_W-1:0] rd_val
);

  logic [ACC_W-1:0] coef_q [M_ROWS];

  for (genvar r = 0; r < M_ROWS; r++) begin : g_coef
    logic row_en;
    assign row_en = wr_vld && (wr_row == RW'(r));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      coef_q[r] <= '0;
      else if (row_en) coef_q[r] <= wr_val;
    end
  end

  assign rd_val = (32'(rd_idx) < M_ROWS) ? coef_q[rd_idx] : '0;

endmodule

// File: rtl/pcaproj_engine.sv
module pcaproj_engine #(
  parameter int N_LEN  = 300,
  parameter int M_ROWS = 4,
  parameter int DATA_W = 32,
  localparam int CW    = (N_LEN > 1) ? $clog2(N_LEN) : 1,
  localparam int RW    = (M_ROWS > 1) ? $clog2(M_ROWS) : 1,
  localparam int DEPTH = M_ROWS * N_LEN,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int ACC_W = 2 * DATA_W + 1 + CW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vec_we,
  input  logic [1:0]        vec_sel,
  input  logic [AW-1:0]     vec_addr,
  input  logic [DATA_W-1:0] vec_wdata,
  input  logic              start,
  output logic              busy,
  output logic              done,
  input  logic [RW-1:0]     rd_idx,
  output logic [ACC_W-1:0]  rd_coef
);

  logic              busy_w;
  logic              wr_en;
  logic              iss_vld, iss_first, iss_last;
  logic [RW-1:0]     iss_row;
  logic [CW-1:0]     iss_col;
  logic [AW-1:0]     iss_bidx;
  logic [DATA_W-1:0] test_q, mean_q, basis_q;
  logic              res_vld, fin;
  logic [RW-1:0]     res_row;
  logic [ACC_W-1:0]  res_val;

  // Storage is frozen while a projection runs
  assign wr_en = vec_we && !busy_w;

  pcaproj_store #(.N_LEN(N_LEN), .M_ROWS(M_ROWS), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_sel  (vec_sel),
    .wr_addr (vec_addr),
    .wr_data (vec_wdata),
    .rd_col  (iss_col),
    .rd_bidx (iss_bidx),
    .test_q  (test_q),
    .mean_q  (mean_q),
    .basis_q (basis_q)
  );

  pcaproj_seq #(.N_LEN(N_LEN), .M_ROWS(M_ROWS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .fin       (fin),
    .busy      (busy_w),
    .done      (done),
    .iss_vld   (iss_vld),
    .iss_first (iss_first),
    .iss_last  (iss_last),
    .iss_row   (iss_row),
    .iss_col   (iss_col),
    .iss_bidx  (iss_bidx)
  );

  pcaproj_mac #(.N_LEN(N_LEN), .M_ROWS(M_ROWS), .DATA_W(DATA_W)) u_mac (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (iss_vld),
    .in_first (iss_first),
    .in_last  (iss_last),
    .in_row   (iss_row),
    .test_i   (test_q),
    .mean_i   (mean_q),
    .basis_i  (basis_q),
    .wr_vld   (res_vld),
    .wr_row   (res_row),
    .wr_val   (res_val),
    .fin      (fin)
  );

  pcaproj_result #(.M_ROWS(M_ROWS), .ACC_W(ACC_W)) u_result (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_vld (res_vld),
    .wr_row (res_row),
    .wr_val (res_val),
    .rd_idx (rd_idx),
    .rd_val (rd_coef)
  );

  assign busy = busy_w;

endmodule

// File: rtl/pcaproj_chk.sv
module pcaproj_chk #(
  parameter int N_LEN  = 300,
  parameter int M_ROWS = 4,
  parameter int ACC_W  = 74,
  parameter int RW     = 2,
  localparam int RUN_LAT = M_ROWS * N_LEN + 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [RW-1:0]    rd_idx,
  input logic [ACC_W-1:0] rd_coef
);

  logic [31:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + 32'd1;
    else           run_cnt <= '0;
  end

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);                                          // R3

  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_cnt == 32'(RUN_LAT)));                                 // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                     // R4

  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);                                               // R4

  AST_COEF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && $stable(rd_idx)) |-> $stable(rd_coef));    // R10

endmodule

bind pcaproj_engine pcaproj_chk #(
  .N_LEN (N_LEN),
  .M_ROWS(M_ROWS),
  .ACC_W (ACC_W),
  .RW    (RW)
) u_pcaproj_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .rd_idx (rd_idx),
  .rd_coef(rd_coef)
);

// File: tb/pcaproj_engine_bench.sv
`timescale 1ns/1ps
module pcaproj_engine_bench;

  localparam int N     = 300;
  localparam int M     = 4;
  localparam int DW    = 32;
  localparam int CW    = $clog2(N);
  localparam int AW    = $clog2(M * N);
  localparam int RW    = $clog2(M);
  localparam int ACC_W = 2 * DW + 1 + CW;
  localparam int LAT   = M * N + 2;

  logic             clk;
  logic             rst_n;
  logic             vec_we;
  logic [1:0]       vec_sel;
  logic [AW-1:0]    vec_addr;
  logic [DW-1:0]    vec_wdata;
  logic             start;
  logic             busy;
  logic             done;
  logic [RW-1:0]    rd_idx;
  logic [ACC_W-1:0] rd_coef;

  int checks = 0;
  int errors = 0;

  pcaproj_engine u_pcaproj_engine (
    .clk(clk), .rst_n(rst_n), .vec_we(vec_we), .vec_sel(vec_sel),
    .vec_addr(vec_addr), .vec_wdata(vec_wdata), .start(start),
    .busy(busy), .done(done), .rd_idx(rd_idx), .rd_coef(rd_coef)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  logic [DW-1:0]    m_test  [N];
  logic [DW-1:0]    m_mean  [N];
  logic [DW-1:0]    m_basis [M*N];
  logic [ACC_W-1:0] m_pend  [M];
  logic [ACC_W-1:0] m_coef  [M];
  int               m_cnt;
  logic             m_done;

  task automatic model_project();
    for (int r = 0; r < M; r++) begin
      logic signed [ACC_W-1:0] acc;
      acc = '0;
      for (int c = 0; c < N; c++) begin
        logic signed [DW:0]      d;
        logic signed [ACC_W-1:0] de, be;
        d  = $signed({m_test[c][DW-1], m_test[c]}) - $signed({m_mean[c][DW-1], m_mean[c]});
        de = d;
        be = $signed(m_basis[r*N + c]);
        acc = acc + de * be;
      end
      m_pend[r] = acc;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt  = 0;
      m_done = 1'b0;
      for (int r = 0; r < M; r++) m_coef[r] = '0;
    end else begin
      m_done = 1'b0;
      if (m_cnt == 0) begin
        if (vec_we) begin
          if (vec_sel == 2'd0 && vec_addr < AW'(N)) m_test[vec_addr[CW-1:0]] = vec_wdata;
          if (vec_sel == 2'd1 && vec_addr < AW'(N)) m_mean[vec_addr[CW-1:0]] = vec_wdata;
          if (vec_sel == 2'd2 && 32'(vec_addr) < M*N) m_basis[vec_addr] = vec_wdata;
        end
        if (start) begin
          model_project();
          m_cnt = LAT;
        end
      end else begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin
          m_done = 1'b1;
          for (int r = 0; r < M; r++) m_coef[r] = m_pend[r];
        end
      end
    end
  end

  // Per-cycle comparison of handshake outputs, half a cycle after the edge
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (busy !== (m_cnt > 0)) begin
        errors++;
        $display("FAIL R3 busy actual %0b expected %0b at %0t", busy, (m_cnt > 0), $time);
      end
      checks++;
      if (done !== m_done) begin
        errors++;
        $display("FAIL R4 done actual %0b expected %0b at %0t", done, m_done, $time);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [1:0] s, input int a, input logic [DW-1:0] d);
    @(negedge clk);
    vec_we    = 1'b1;
    vec_sel   = s;
    vec_addr  = AW'(a);
    vec_wdata = d;
  endtask

  task automatic wr_end();
    @(negedge clk);
    vec_we = 1'b0;
  endtask

  // mode 0: mixed values; 1: extreme operands; 2: test equals mean
  task automatic load(input int mode);
    for (int c = 0; c < N; c++) begin
      logic [DW-1:0] t, mn;
      case (mode)
        1:       begin t = 32'h8000_0000; mn = 32'h7fff_ffff; end
        2:       begin t = DW'(c * 1000 - 7); mn = t; end
        default: begin t = DW'(c * 37 - 5000); mn = DW'((c % 7) * 100 - 250); end
      endcase
      wr(2'd0, c, t);
      wr(2'd1, c, mn);
    end
    for (int i = 0; i < M * N; i++) begin
      logic [DW-1:0] b;
      if (mode == 1) b = 32'h8000_0000;
      else           b = DW'(((i / N) + 1) * (i % 13) - 6);
      wr(2'd2, i, b);
    end
    wr(2'd3, 0, 32'hdead_beef);   // unused select, must store nothing (R1)
    wr_end();
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    logic seen;
    seen = 1'b0;
    for (int k = 0; k < LAT + 20; k++) begin
      @(negedge clk);
      if (done) begin
        seen = 1'b1;
        break;
      end
    end
    checks++;
    if (!seen) begin
      errors++;
      $display("FAIL %s done actual 0 expected 1 within %0d cycles", tag, LAT + 20);
    end
  endtask

  task automatic check_coefs(input string tag);
    for (int r = 0; r < M; r++) begin
      @(negedge clk);
      rd_idx = RW'(r);
      #1;
      checks++;
      if (rd_coef !== m_coef[r]) begin
        errors++;
        $display("FAIL %s coef[%0d] actual %0h expected %0h", tag, r, rd_coef, m_coef[r]);
      end
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R3 actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    rst_n     = 1'b0;
    vec_we    = 1'b0;
    vec_sel   = 2'd0;
    vec_addr  = '0;
    vec_wdata = '0;
    start     = 1'b0;
    rd_idx    = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R2: reset state
    check_coefs("R2");

    // R1, R5: mixed signed values
    load(0);
    pulse_start();
    wait_done("R3");
    check_coefs("R5_R1");

    // R6: extreme operands, wide accumulation
    load(1);
    pulse_start();
    wait_done("R3");
    check_coefs("R6");

    // R9: zero centred vector after a large run must give zeros
    load(2);
    pulse_start();
    wait_done("R3");
    check_coefs("R9");

    // R7, R8: start held and re-pulsed, writes issued while busy
    load(0);
    @(negedge clk);
    start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    repeat (100) @(negedge clk);
    start     = 1'b1;
    vec_we    = 1'b1;
    vec_sel   = 2'd2;
    vec_addr  = AW'(5);
    vec_wdata = 32'h7fff_0000;
    @(negedge clk);
    start     = 1'b0;
    vec_sel   = 2'd0;
    vec_addr  = AW'(3);
    vec_wdata = 32'h1234_5678;
    @(negedge clk);
    vec_we = 1'b0;
    wait_done("R7");
    check_coefs("R7");

    // R8: rerun without reloading; dropped writes must not appear
    pulse_start();
    wait_done("R8");
    check_coefs("R8");

    // R10: coefficients hold while idle
    repeat (50) @(negedge clk);
    check_coefs("R10");

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule